// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block watches a software kick and asks the reset controller for a system reset when no kick arrives within a programmable window. A kick is any change of level on the synchronized watchdog input, in either direction. A one-cycle acknowledge pulse from the serial bus interface also counts as a kick. The window is counted in millisecond ticks that arrive from a shared timebase. A 3-bit code selects one of five window lengths, each double the one before, or an idle mode. Idle mode is meant for debug sessions and for the boot period before software starts kicking.

The block does not build the reset pulse. It raises a one-cycle expiry request, and the reset controller answers by holding its reset-active flag for the length of the pulse. While that flag is high the count stays at zero. When the flag drops, a fresh window begins. Without kicks the system therefore cycles through timeout, reset, timeout, reset. All pins are plain control and status levels or pulses. The block has no data stream and no handshake.

Top module: `wdog_timer`

## Requirements
- R1: A change of level on `wdi` clears the count. The change is found by comparing the value in this clock with the value in the previous clock. Rising and falling changes act the same.
- R2: A `tmo_code` of 3'b000 or 3'b001 selects idle mode. In idle mode the count is held at zero, `expire_req` never rises and `wd_running` is low.
- R3: Codes 3'b011, 3'b100, 3'b101, 3'b110 and 3'b111 select a window of BASE_TICKS, 2, 4, 8 and 16 times BASE_TICKS ticks. With the default BASE_TICKS of 400 and a 1 ms tick, these are 0.4 s, 0.8 s, 1.6 s, 3.2 s and 6.4 s.
- R4: A window of N ticks fills on the N-th `ms_tick` that arrives with no clear in between. `expire_req` is high for exactly the one clock after the clock edge that samples that tick. The count then restarts from zero.
- R5: A high `bus_ack_kick`, sampled at a clock edge, clears the count in the same way as a change of level on `wdi`.
- R6: While `rst_active` is high the count is held at zero and no expiry is requested. After it falls, a full new window must pass before the next expiry. With no kicks the expiries repeat once per window.
- R7: A change of `tmo_code` between two clock edges clears the count, so the new window is timed from the change.
- R8: The count advances only at clock edges where `ms_tick` is high. With a tick every k clocks, the window lasts k times as many clocks.
- R9: `wd_running` is high exactly when the code is not idle and `rst_active` is low.
- R10: While `rst_n` is low, `expire_req` is low and the count and edge history are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdi | input | 1 | Watchdog kick level, already synchronized to clk |
| bus_ack_kick | input | 1 | One-cycle kick pulse from the serial bus acknowledge |
| tmo_code | input | 3 | Window select; 00x means idle |
| rst_active | input | 1 | High while the reset controller drives its reset pulse |
| ms_tick | input | 1 | One-cycle millisecond timebase pulse |
| expire_req | output | 1 | One-cycle request for a reset pulse |
| wd_running | output | 1 | High while the watchdog is counting or ready to count |

## Verification
The bench steps through all five window codes. It measures the gap between consecutive expiries, so a design with an off-by-one limit, or with the wrong shift for a code, shows a gap that is a few clocks or a factor of two away from the expected value. Kicks are spaced shorter than the window: on `wdi` they alternate between rising and falling changes, and on the bus pulse they are single pulses. A design that misses either direction, or ignores the pulse, expires during these runs. A code change partway through a window and a long reset-active hold are both timed against the next expiry. A design that carries the old count into the new window expires early, and one that counts during reset never re-arms cleanly. A sparse tick pattern catches a counter that advances on clocks instead of on ticks.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef logic [2:0] wd_code_t;

  localparam wd_code_t WD_CODE_SHORTEST = 3'b011;

  function automatic logic wd_is_idle(wd_code_t c);
    return c[2:1] == 2'b00;
  endfunction
endpackage

// File: rtl/wd_kick_detect.sv
module wd_kick_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi,
  input  logic bus_ack_kick,
  output logic kick
);
  logic wdi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdi_q <= 1'b0;
    else        wdi_q <= wdi;
  end

  // either polarity of change counts, as does the bus acknowledge
  assign kick = (wdi ^ wdi_q) | bus_ack_kick;
endmodule

// File: rtl/wd_limit_sel.sv
module wd_limit_sel
  import wd_pkg::*;
#(
  parameter int BASE_TICKS = 400,
  parameter int CNT_W      = 13
) (
  input  wd_code_t           code,
  output logic [CNT_W-1:0]   limit,
  output logic               idle
);
  logic [2:0] shamt;

  always_comb begin
    idle  = wd_is_idle(code);
    shamt = code - WD_CODE_SHORTEST;
    if (idle) limit = CNT_W'(BASE_TICKS);
    else      limit = CNT_W'(BASE_TICKS) << shamt;
  end
endmodule

// File: rtl/wd_window_cnt.sv
module wd_window_cnt #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             last_tick;

  assign last_tick = (cnt + CNT_W'(1)) == limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (tick) begin
        if (last_tick) begin
          cnt    <= '0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wd_pkg::*;
#(
  parameter int BASE_TICKS = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdi,
  input  logic       bus_ack_kick,
  input  logic [2:0] tmo_code,
  input  logic       rst_active,
  input  logic       ms_tick,
  output logic       expire_req,
  output logic       wd_running
);
  localparam int CNT_W = $clog2(BASE_TICKS * 16 + 1);

  logic             kick;
  logic             idle;
  logic [CNT_W-1:0] limit;
  wd_code_t         code_q;
  logic             code_chg;
  logic             clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= tmo_code;
  end

  assign code_chg = code_q != tmo_code;

  wd_kick_detect u_kick (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdi          (wdi),
    .bus_ack_kick (bus_ack_kick),
    .kick         (kick)
  );

  wd_limit_sel #(
    .BASE_TICKS (BASE_TICKS),
    .CNT_W      (CNT_W)
  ) u_lim (
    .code  (tmo_code),
    .limit (limit),
    .idle  (idle)
  );

  assign clear = rst_active | idle | kick | code_chg;

  wd_window_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .tick   (ms_tick),
    .limit  (limit),
    .expire (expire_req)
  );

  assign wd_running = ~idle & ~rst_active;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wdi,
  input logic       bus_ack_kick,
  input logic [2:0] tmo_code,
  input logic       rst_active,
  input logic       ms_tick,
  input logic       expire_req,
  input logic       wd_running
);
  AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_req |=> !expire_req); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_code[2:1] == 2'b00) |=> !expire_req); // R2

  AST_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> !expire_req); // R6

  AST_ACK_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack_kick |=> !expire_req); // R5

  AST_WDI_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (wdi != $past(wdi)) |=> !expire_req); // R1

  AST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> !expire_req); // R8

  AST_RUN_BEFORE_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_req |-> $past(wd_running)); // R9
endmodule

bind wdog_timer wdog_timer_chk u_chk (.*);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wdi = 1'b0;
  logic       bus_ack_kick = 1'b0;
  logic [2:0] tmo_code = 3'b000;
  logic       rst_active = 1'b0;
  logic       ms_tick = 1'b0;
  logic       expire_req;
  logic       wd_running;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tick_div = 1;
  int tick_ph = 0;
  int exp_times[$];

  // reference model state
  int m_cnt = 0;
  logic m_prev_wdi = 1'b0;
  logic [2:0] m_prev_code = 3'b000;
  logic m_exp = 1'b0;

  wdog_timer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdi          (wdi),
    .bus_ack_kick (bus_ack_kick),
    .tmo_code     (tmo_code),
    .rst_active   (rst_active),
    .ms_tick      (ms_tick),
    .expire_req   (expire_req),
    .wd_running   (wd_running)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // tick generator
  always @(posedge clk) begin
    #1;
    tick_ph++;
    ms_tick = (tick_ph % tick_div) == 0;
  end

  // behavioural reference, updated on every edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_prev_wdi = 1'b0; m_prev_code = 3'b000; m_exp = 1'b0;
    end else begin
      bit idle_now;
      bit clr;
      int lim;
      idle_now = tmo_code < 3'd2;
      clr = rst_active || idle_now || (wdi != m_prev_wdi) || bus_ack_kick
            || (tmo_code != m_prev_code);
      lim = idle_now ? 400 : (400 << (int'(tmo_code) - 3));
      m_exp = 1'b0;
      if (clr) m_cnt = 0;
      else if (ms_tick) begin
        if (m_cnt == lim - 1) begin m_cnt = 0; m_exp = 1'b1; end
        else m_cnt++;
      end
      m_prev_wdi = wdi;
      m_prev_code = tmo_code;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(expire_req === m_exp, "R4", int'(expire_req), int'(m_exp));
      check(wd_running === ((tmo_code >= 3'd2) && !rst_active), "R9",
            int'(wd_running), int'((tmo_code >= 3'd2) && !rst_active));
      if (expire_req === 1'b1) exp_times.push_back(cyc);
    end
  end

  initial begin
    #(150000 * 5);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int chg_cyc;
    // R10: reset state
    step(3);
    @(negedge clk);
    check(expire_req === 1'b0, "R10", int'(expire_req), 0);
    check(wd_running === 1'b0, "R10 idle code", int'(wd_running), 0);
    rst_n = 1'b1;
    step(2);

    // R2: idle codes
    exp_times.delete();
    tmo_code = 3'b000; step(1000);
    tmo_code = 3'b001; step(1000);
    check(exp_times.size() == 0, "R2", exp_times.size(), 0);

    // R3: every window length, two expiries each
    for (int c = 3; c <= 7; c++) begin
      int lim;
      lim = 400 << (c - 3);
      tmo_code = 3'b000; step(2);
      exp_times.delete();
      tmo_code = 3'(c);
      step(2 * lim + 20);
      check(exp_times.size() == 2, "R3 count", exp_times.size(), 2);
      if (exp_times.size() == 2)
        check(exp_times[1] - exp_times[0] == lim, "R3 interval",
              exp_times[1] - exp_times[0], lim);
    end

    // R1: alternating rising and falling changes on wdi
    tmo_code = 3'b000; step(2);
    tmo_code = 3'b011; step(2);
    exp_times.delete();
    for (int i = 0; i < 10; i++) begin
      step(300);
      wdi = ~wdi;
    end
    check(exp_times.size() == 0, "R1", exp_times.size(), 0);

    // R5: bus acknowledge pulses
    exp_times.delete();
    for (int i = 0; i < 10; i++) begin
      step(350);
      bus_ack_kick = 1'b1; step(1);
      bus_ack_kick = 1'b0;
    end
    check(exp_times.size() == 0, "R5", exp_times.size(), 0);

    // R6: reset-active hold then re-arm
    rst_active = 1'b1;
    exp_times.delete();
    step(1000);
    check(exp_times.size() == 0, "R6 hold", exp_times.size(), 0);
    @(negedge clk);
    check(wd_running === 1'b0, "R9 during reset", int'(wd_running), 0);
    step(1);
    rst_active = 1'b0;
    exp_times.delete();
    step(850);
    check(exp_times.size() == 2, "R6 re-arm", exp_times.size(), 2);
    if (exp_times.size() == 2)
      check(exp_times[1] - exp_times[0] == 400, "R6 repeat",
            exp_times[1] - exp_times[0], 400);

    // R7: code change mid-window
    tmo_code = 3'b000; step(2);
    tmo_code = 3'b011; step(300);
    exp_times.delete();
    tmo_code = 3'b100;
    chg_cyc = cyc;
    step(850);
    check(exp_times.size() == 1, "R7 count", exp_times.size(), 1);
    if (exp_times.size() >= 1)
      check((exp_times[0] - chg_cyc >= 795) && (exp_times[0] - chg_cyc <= 805),
            "R7 timing", exp_times[0] - chg_cyc, 800);

    // R8: sparse ticks
    tick_div = 4;
    tmo_code = 3'b000; step(2);
    exp_times.delete();
    tmo_code = 3'b011;
    step(3300);
    check(exp_times.size() == 2, "R8 count", exp_times.size(), 2);
    if (exp_times.size() == 2)
      check(exp_times[1] - exp_times[0] == 1600, "R8 interval",
            exp_times[1] - exp_times[0], 1600);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule